// File: doc/BRIEF.md
# Receive Character FIFO with Error Status

This block sits between a serial receiver and the logic that reads received characters. Every time the receiver completes a character it writes the data byte and three per-character flags: break detected, framing error, and parity error. In multidrop operation the parity-error flag carries the address/data marker instead. The block holds up to four characters. The oldest one is always presented on the read side, and a pop strobe removes it.

The status outputs have two reporting styles, chosen by a mode input. In per-character style the flags belong to the character currently presented at the head. In accumulated style each flag is the sticky OR of that flag over every character that has reached the head since the last error-clear strobe. A write that arrives while all four slots are occupied is discarded and sets an overrun flag. The same error-clear strobe resets that flag.

Top module: `rxq_fifo`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rd_valid`, `full`, `overrun`, `rd_data` and all three status outputs are 0.
- R2: Characters are read out in write order. `rd_valid` is high whenever at least one character is held, and `rd_data` shows the oldest character (0 when empty). `rd_en` removes it. A pop on an empty FIFO has no effect.
- R3: `full` is high when 4 characters are held. A write in a cycle where the FIFO is full is discarded, even if a pop happens in the same cycle, and the held contents are unchanged.
- R4: When `blk_mode` = 0, the status outputs equal the flags stored with the head character. They are all 0 when the FIFO is empty.
- R5: When `blk_mode` = 1, each status output is the OR of that flag over every character that became head since the last `err_clr`. Becoming head includes a write into an empty FIFO. Popping characters does not lower an accumulated flag.
- R6: `err_clr` zeroes the accumulated flags. If a character becomes head in the same cycle, the accumulator holds only that character's flags afterwards.
- R7: A discarded write sets `overrun` from the next cycle. `err_clr` clears it, unless a write is discarded in that same cycle, in which case `overrun` stays set.
- R8: When `multidrop` = 1, `stat_pe` reports the head character's address/data flag (0 when empty) in both modes. `stat_brk` and `stat_fe` still follow `blk_mode`.
- R9: Accumulation runs in both modes. Switching `blk_mode` from 0 to 1 shows what has accumulated since the last `err_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Receiver delivers one character |
| wr_data | input | 8 | Character data |
| wr_brk | input | 1 | Break flag of the written character |
| wr_fe | input | 1 | Framing-error flag of the written character |
| wr_pe | input | 1 | Parity-error flag, or address marker in multidrop |
| rd_en | input | 1 | Pop the head character |
| err_clr | input | 1 | Error-clear strobe |
| blk_mode | input | 1 | 1 = accumulated status, 0 = per-character status |
| multidrop | input | 1 | Multidrop operation, parity flag is the address marker |
| rd_valid | output | 1 | At least one character held |
| rd_data | output | 8 | Head character data |
| full | output | 1 | Four characters held |
| stat_brk | output | 1 | Reported break status |
| stat_fe | output | 1 | Reported framing-error status |
| stat_pe | output | 1 | Reported parity-error or address status |
| overrun | output | 1 | A write was discarded since the last clear |

## Verification
The assertions assume that `blk_mode` and `multidrop` are plain levels, and that a write or pop is a single-cycle strobe sampled on each clock edge. They assume nothing about how writes and pops are spaced. The stimulus changes every input only at the falling clock edge. The mode inputs are held steady through each directed scenario, and they switch only between scenarios or in the random phase, where any combination of strobes is legal.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Per-character condition flags; packed order brk, fe, pe (MSB..LSB)
    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
    } rxq_flags_t;

    localparam int FLAG_W = $bits(rxq_flags_t);

    function automatic rxq_flags_t flags_merge(input rxq_flags_t a, input rxq_flags_t b);
        return a | b;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int WIDTH = 11,
    parameter int DEPTH = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_req,
    input  logic [WIDTH-1:0]                      wr_word,
    input  logic                                  rd_req,
    output logic [WIDTH-1:0]                      head_word,
    output logic [WIDTH-1:0]                      next_word,
    output logic [$clog2(DEPTH+1)-1:0]            cnt,
    output logic                                  wr_ok,
    output logic                                  rd_ok
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, rd_ptr_nx;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign wr_ok     = wr_req && (cnt < CNT_W'(DEPTH));
    assign rd_ok     = rd_req && (cnt != '0);
    assign rd_ptr_nx = ptr_inc(rd_ptr);
    assign head_word = mem[rd_ptr];
    assign next_word = mem[rd_ptr_nx];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (rd_ok) rd_ptr <= rd_ptr_nx;
            case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       new_head,
    input  rxq_flags_t new_flags,
    input  logic       head_valid,
    input  rxq_flags_t head_flags,
    input  logic       blk_mode,
    input  logic       multidrop,
    input  logic       clr,
    input  logic       drop,
    output rxq_flags_t stat,
    output logic       overrun
);
    rxq_flags_t acc_q;
    rxq_flags_t shown;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            overrun <= 1'b0;
        end else begin
            if (clr) begin
                acc_q <= new_head ? new_flags : '0;
            end else if (new_head) begin
                acc_q <= flags_merge(acc_q, new_flags);
            end
            overrun <= (overrun && !clr) || drop;
        end
    end

    always_comb begin
        shown = head_valid ? head_flags : '0;
        stat  = blk_mode ? acc_q : shown;
        if (multidrop) begin
            stat.pe = shown.pe;
        end
    end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_brk,
    input  logic              wr_fe,
    input  logic              wr_pe,
    input  logic              rd_en,
    input  logic              err_clr,
    input  logic              blk_mode,
    input  logic              multidrop,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              stat_brk,
    output logic              stat_fe,
    output logic              stat_pe,
    output logic              overrun
);
    localparam int WORD_W = DATA_W + FLAG_W;
    localparam int CNT_W  = $clog2(DEPTH+1);

    logic [WORD_W-1:0] in_word, head_word, next_word;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W:0]    cnt_after;
    logic              wr_ok, rd_ok, new_head, drop;
    rxq_flags_t        wr_flags, head_flags, next_flags, new_flags, stat;

    assign wr_flags = '{brk: wr_brk, fe: wr_fe, pe: wr_pe};
    assign in_word  = {wr_data, wr_flags};

    rxq_store #(.WIDTH(WORD_W), .DEPTH(DEPTH)) store_i (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_en),
        .wr_word   (in_word),
        .rd_req    (rd_en),
        .head_word (head_word),
        .next_word (next_word),
        .cnt       (cnt),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok)
    );

    assign head_flags = head_word[FLAG_W-1:0];
    assign next_flags = next_word[FLAG_W-1:0];
    assign cnt_after  = {1'b0, cnt} + (CNT_W+1)'(wr_ok) - (CNT_W+1)'(rd_ok);
    assign drop       = wr_en && !wr_ok;

    // A character becomes head after a pop that leaves something behind,
    // or after a write into an empty FIFO.
    always_comb begin
        if (rd_ok) begin
            new_head = (cnt_after != '0);
        end else begin
            new_head = (cnt == '0) && wr_ok;
        end
        new_flags = (rd_ok && cnt >= CNT_W'(2)) ? next_flags : wr_flags;
    end

    assign rd_valid = (cnt != '0);
    assign full     = (cnt == CNT_W'(DEPTH));
    assign rd_data  = rd_valid ? head_word[WORD_W-1:FLAG_W] : '0;

    rxq_status status_i (
        .clk        (clk),
        .rst        (rst),
        .new_head   (new_head),
        .new_flags  (new_flags),
        .head_valid (rd_valid),
        .head_flags (head_flags),
        .blk_mode   (blk_mode),
        .multidrop  (multidrop),
        .clr        (err_clr),
        .drop       (drop),
        .stat       (stat),
        .overrun    (overrun)
    );

    assign stat_brk = stat.brk;
    assign stat_fe  = stat.fe;
    assign stat_pe  = stat.pe;
endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              err_clr,
    input logic              blk_mode,
    input logic              multidrop,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              full,
    input logic              stat_brk,
    input logic              stat_fe,
    input logic              stat_pe,
    input logic              overrun
);
    AST_EMPTY_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0)); // R2
    AST_FULL_HAS_HEAD: assert property (@(posedge clk) disable iff (rst)
        full |-> rd_valid); // R3
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && !rd_en) |=> full); // R3
    AST_CHAR_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!rd_valid && !blk_mode) |-> !(stat_brk || stat_fe || stat_pe)); // R4
    AST_ACC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (blk_mode && stat_brk && !err_clr) |=> (!blk_mode || stat_brk)); // R5
    AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en) |=> overrun); // R7
    AST_CLR_DROPS_OVR: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !(full && wr_en)) |=> !overrun); // R7
    AST_MD_EMPTY_PE: assert property (@(posedge clk) disable iff (rst)
        (multidrop && !rd_valid) |-> !stat_pe); // R8
endmodule

bind rxq_fifo rxq_fifo_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .err_clr   (err_clr),
    .blk_mode  (blk_mode),
    .multidrop (multidrop),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .full      (full),
    .stat_brk  (stat_brk),
    .stat_fe   (stat_fe),
    .stat_pe   (stat_pe),
    .overrun   (overrun)
);

// File: tb/rxq_fifo_tb_top.sv
module rxq_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 0, wr_brk = 0, wr_fe = 0, wr_pe = 0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 0, err_clr = 0, blk_mode = 0, multidrop = 0;
    logic       rd_valid, full, stat_brk, stat_fe, stat_pe, overrun;
    logic [7:0] rd_data;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R4";

    always #2 clk = ~clk;

    rxq_fifo dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_brk(wr_brk), .wr_fe(wr_fe), .wr_pe(wr_pe), .rd_en(rd_en),
        .err_clr(err_clr), .blk_mode(blk_mode), .multidrop(multidrop),
        .rd_valid(rd_valid), .rd_data(rd_data), .full(full),
        .stat_brk(stat_brk), .stat_fe(stat_fe), .stat_pe(stat_pe),
        .overrun(overrun)
    );

    // Reference model: entry = {data[7:0], brk, fe, pe}
    logic [10:0] q[$];
    logic [2:0]  m_acc = '0;
    logic        m_ovr = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_acc = '0;
            m_ovr = 1'b0;
        end else begin
            int  old_n;
            bit  wok, rok, nh, drp;
            old_n = q.size();
            wok   = wr_en && (old_n < 4);
            drp   = wr_en && (old_n == 4);
            rok   = rd_en && (old_n > 0);
            if (rok) void'(q.pop_front());
            if (wok) q.push_back({wr_data, wr_brk, wr_fe, wr_pe});
            nh = rok ? (q.size() > 0) : (old_n == 0 && wok);
            if (err_clr)  m_acc = nh ? q[0][2:0] : 3'b000;
            else if (nh)  m_acc = m_acc | q[0][2:0];
            m_ovr = (m_ovr && !err_clr) || drp;
        end
    end

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [2:0] hf, ex;
        bit         v;
        v  = q.size() > 0;
        hf = v ? q[0][2:0] : 3'b000;
        ex = blk_mode ? m_acc : hf;
        if (multidrop) ex[0] = hf[0];
        chk("R2 valid/data", {rd_valid, rd_data}, {v, v ? q[0][10:3] : 8'h00});
        chk("R3 full", {8'h00, full}, {8'h00, q.size() == 4});
        chk("R7 overrun", {8'h00, overrun}, {8'h00, m_ovr});
        chk({cur_req, " brk/fe"}, {7'h00, stat_brk, stat_fe}, {7'h00, ex[2:1]});
        chk(multidrop ? "R8 pe" : {cur_req, " pe"}, {8'h00, stat_pe}, {8'h00, ex[0]});
    endtask

    always @(negedge clk) begin
        if (!rst) compare_all();
    end

    task automatic cyc(input bit w, input logic [7:0] d, input logic [2:0] f,
                       input bit r, input bit c);
        @(negedge clk);
        wr_en = w; wr_data = d; {wr_brk, wr_fe, wr_pe} = f;
        rd_en = r; err_clr = c;
    endtask

    task automatic idle();
        cyc(0, 8'h00, 3'b000, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {rd_valid, full, overrun, stat_brk, stat_fe, stat_pe, 3'b000},
            9'h000);
        chk("R1 reset data", {1'b0, rd_data}, 9'h000);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {rd_valid, full, overrun, stat_brk, stat_fe, stat_pe, 3'b000},
            9'h000);

        // R2: ordering, pop on empty ignored
        cur_req = "R4";
        cyc(1, 8'h11, 3'b000, 0, 0);
        cyc(1, 8'h22, 3'b000, 0, 0);
        cyc(1, 8'h33, 3'b000, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 8'h00, 3'b000, 1, 0);
        idle();

        // R3/R7: fill, drop on full, write+pop at full, clear vs drop
        for (int i = 0; i < 4; i++) cyc(1, 8'h40 + 8'(i), 3'b000, 0, 0);
        cyc(1, 8'hEE, 3'b111, 0, 0);
        cyc(1, 8'hEF, 3'b111, 1, 0);
        cyc(0, 8'h00, 3'b000, 0, 1);
        cyc(1, 8'hF0, 3'b000, 0, 0);
        cyc(1, 8'hF1, 3'b000, 0, 1);
        idle();
        cyc(0, 8'h00, 3'b000, 0, 1);
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 3'b000, 1, 0);

        // R4: per-character flags of the head
        cyc(1, 8'h51, 3'b100, 0, 0);
        cyc(1, 8'h52, 3'b010, 0, 0);
        cyc(1, 8'h53, 3'b001, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 3'b000, 1, 0);

        // R5: accumulated flags, sticky through pops
        cur_req = "R5";
        cyc(0, 8'h00, 3'b000, 0, 1);
        blk_mode = 1;
        cyc(1, 8'h61, 3'b100, 0, 0);
        cyc(1, 8'h62, 3'b001, 0, 0);
        cyc(1, 8'h63, 3'b010, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 3'b000, 1, 0);

        // R6: clear, and clear with a same-cycle new head
        cur_req = "R6";
        cyc(1, 8'h71, 3'b100, 0, 1);
        cyc(1, 8'h72, 3'b010, 0, 0);
        cyc(0, 8'h00, 3'b000, 1, 1);
        cyc(0, 8'h00, 3'b000, 0, 1);
        cyc(0, 8'h00, 3'b000, 1, 0);

        // R8: multidrop, pe follows head in both modes
        multidrop = 1;
        cur_req = "R8";
        for (int m = 0; m < 2; m++) begin
            blk_mode = m[0];
            cyc(1, 8'h81, 3'b101, 0, 0);
            cyc(1, 8'h82, 3'b000, 0, 0);
            cyc(1, 8'h83, 3'b011, 0, 0);
            for (int i = 0; i < 4; i++) cyc(0, 8'h00, 3'b000, 1, 0);
        end
        multidrop = 0;

        // R9: accumulate in character mode, then switch
        cur_req = "R9";
        blk_mode = 0;
        cyc(0, 8'h00, 3'b000, 0, 1);
        cyc(1, 8'h91, 3'b010, 0, 0);
        cyc(1, 8'h92, 3'b001, 0, 0);
        cyc(0, 8'h00, 3'b000, 1, 0);
        idle();
        blk_mode = 1;
        idle();
        cyc(0, 8'h00, 3'b000, 1, 0);
        idle();

        // Random mix across all modes
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) begin
                blk_mode  = 1'($urandom);
                multidrop = 1'($urandom);
                cur_req   = blk_mode ? "R5" : "R4";
            end
            cyc(1'($urandom_range(0, 99) < 55), 8'($urandom), 3'($urandom),
                1'($urandom_range(0, 99) < 45), 1'($urandom_range(0, 99) < 8));
        end
        idle();
        idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule